// File: doc/BRIEF.md
# I2C Master Command-Word Sequencer

This block is the transaction engine of an I2C master. Software-facing logic pushes 11-bit command words into a small command queue. Each word either carries a byte to send or asks for a byte to be received. It may also ask for a STOP once the byte is done, or for a repeated START before the byte. The sequencer turns this stream into byte-level bus primitives: START, repeated START, STOP, write-a-byte (which returns the acknowledge bit) and read-a-byte (which is given the acknowledge bit to drive). A separate bit-level engine, outside this block, executes those primitives on the wires. Received bytes land in a receive queue.

The sequencer sends the 7-bit target address from a static input at the start of each transaction and after every repeated START. It reports failures as a sticky abort-cause vector. An abort raises a one-cycle abort event and empties both queues. It also gives one-cycle pulses when a START or STOP completes. An enable request governs when new transactions may begin. The enable-status output follows that request only while no transaction is running.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: After reset the block is idle: `busActive`=0, `enableStatus`=0, `rxEmpty`=1, `abortSrc`=0 and `priReq`=0.
- R2: `enableStatus` copies `enableReq` only while no transaction runs. A command word pushed while `enableStatus`=0 is discarded and never reaches the bus.
- R3: The first word taken from idle issues a START (`priOp`=0), then a write of the address byte {`targetAddr`, read flag of that word}. A `startDet` pulse marks each completed START or repeated START.
- R4: Command word layout: bits 7:0 are the data byte, bit 8 set marks a read request (data bits ignored), bit 9 asks for a STOP after the byte, bit 10 asks for a repeated START before it. A write word issues a write primitive (`priOp`=3) carrying bits 7:0.
- R5: A read word issues a read primitive (`priOp`=4). The byte is driven with ACK (`priAckOut`=1) unless the word carries the STOP bit (then NACK), and the received byte enters the receive queue in order.
- R6: A word with bit 10 set, or whose read flag differs from the current direction, first issues a repeated START (`priOp`=1) and then the address byte with the new direction.
- R7: After a byte whose word carries bit 9, a STOP (`priOp`=2) is issued. Its completion pulses `stopDet`, and the block is idle on the next cycle.
- R8: When the command queue runs dry without a pending STOP, the block holds the bus: `busHold`=1, `priReq`=0, `busActive`=1. It resumes with the next pushed word.
- R9: An unacknowledged address byte sets `abortSrc` bit 0, pulses `abortEvt`, empties both queues and issues a STOP.
- R10: An unacknowledged data byte sets `abortSrc` bit 3, pulses `abortEvt`, empties both queues (received bytes included) and issues a STOP.
- R11: Lost arbitration on any written byte sets `abortSrc` bit 12, pulses `abortEvt`, empties both queues and returns to idle without issuing a STOP.
- R12: `abortSrc` bits stay set until the next transaction is started from idle, which clears them.
- R13: A command word pushed in the same cycle as an abort's queue flush is discarded.
- R14: If `enableReq` drops while the bus is held for lack of words, a STOP is issued, and `enableStatus` falls once idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enableReq | input | 1 | Request to enable the controller |
| enableStatus | output | 1 | Controller enabled; follows the request when idle |
| busActive | output | 1 | A transaction is in progress |
| busHold | output | 1 | Bus held waiting for command words |
| targetAddr | input | 7 | 7-bit target address |
| cmdPush | input | 1 | Push a command word |
| cmdWord | input | 11 | Command word |
| cmdFull | output | 1 | Command queue full |
| rxPop | input | 1 | Pop the receive queue |
| rxData | output | 8 | Head of the receive queue |
| rxEmpty | output | 1 | Receive queue empty |
| rxFull | output | 1 | Receive queue full |
| priReq | output | 1 | Primitive request, held until done |
| priOp | output | 3 | Primitive: 0 START, 1 repeated START, 2 STOP, 3 write, 4 read |
| priWrByte | output | 8 | Byte to write |
| priAckOut | output | 1 | Acknowledge to drive after a read (1 = ACK) |
| priDone | input | 1 | One-cycle completion of the current primitive |
| priAckIn | input | 1 | Acknowledge seen after a write (1 = ACK) |
| priArbLost | input | 1 | Arbitration lost during the write |
| priRdByte | input | 8 | Byte received by a read |
| abortSrc | output | 13 | Sticky abort causes: bit 0 address NACK, bit 3 data NACK, bit 12 arbitration lost |
| abortEvt | output | 1 | One-cycle abort event |
| startDet | output | 1 | One-cycle pulse on START / repeated START completion |
| stopDet | output | 1 | One-cycle pulse on STOP completion |

## Verification
The abort flush of the command queue and a new command push can land in the same clock cycle. Then the flush must win, or a stray word would start a fresh transaction. The bench's bus model drives the NACK completion of the address byte and a new STOP-carrying write word in one and the same cycle. It then watches the bus primitives for a long quiet window. Any START after the abort's STOP counts as a mismatch, and so does a trace longer than START, address, STOP.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int CMD_W       = 11;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 7;
  localparam int CMD_RD_BIT  = 8;
  localparam int CMD_STP_BIT = 9;
  localparam int CMD_RS_BIT  = 10;
  localparam int ABORT_W     = 13;
  localparam int ABT_ADDR_NACK = 0;
  localparam int ABT_DATA_NACK = 3;
  localparam int ABT_ARB_LOST  = 12;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } busOp_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_XFER, S_NEXT, S_STOP
  } seqState_e;

  typedef struct packed {
    logic cmdPop;
    logic rxPush;
    logic flush;
    logic clrAbort;
    logic setAddrNack;
    logic setDataNack;
    logic setArbLost;
  } dpCtl_t;
endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign rdata  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  // R13: a flush leaves the queue empty even if a push came with it
  a_r13_flush_wins: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);
  a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import i2cseq_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int RX_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              enableStatus,
  input  logic              cmdPush,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [DATA_W-1:0] priRdByte,
  input  logic              rxPop,
  output logic [CMD_W-1:0]  headWord,
  output logic              cmdEmpty,
  output logic              cmdFull,
  output logic [DATA_W-1:0] rxData,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic [ABORT_W-1:0] abortSrc
);
  logic acceptPush;
  logic [ABORT_W-1:0] setMask;

  assign acceptPush = cmdPush && enableStatus;

  seq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) i_cmdQ (
    .clk(clk), .rstN(rstN), .flush(ctl.flush),
    .push(acceptPush), .wdata(cmdWord),
    .pop(ctl.cmdPop), .rdata(headWord),
    .empty(cmdEmpty), .full(cmdFull)
  );

  seq_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) i_rxQ (
    .clk(clk), .rstN(rstN), .flush(ctl.flush),
    .push(ctl.rxPush), .wdata(priRdByte),
    .pop(rxPop), .rdata(rxData),
    .empty(rxEmpty), .full(rxFull)
  );

  always_comb begin
    setMask = '0;
    setMask[ABT_ADDR_NACK] = ctl.setAddrNack;
    setMask[ABT_DATA_NACK] = ctl.setDataNack;
    setMask[ABT_ARB_LOST]  = ctl.setArbLost;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             abortSrc <= '0;
    else if (ctl.clrAbort) abortSrc <= '0;
    else                   abortSrc <= abortSrc | setMask;
  end

  // R12: causes are never dropped except by a clear
  a_r12_abort_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clrAbort |=> ((abortSrc & $past(abortSrc)) == $past(abortSrc)));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import i2cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enableReq,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [CMD_W-1:0]  headWord,
  input  logic              cmdEmpty,
  input  logic              priDone,
  input  logic              priAckIn,
  input  logic              priArbLost,
  output dpCtl_t            ctl,
  output logic              priReq,
  output busOp_e            priOp,
  output logic [DATA_W-1:0] priWrByte,
  output logic              priAckOut,
  output logic              enableStatus,
  output logic              busActive,
  output logic              busHold,
  output logic              abortEvt,
  output logic              startDet,
  output logic              stopDet
);
  seqState_e state, nextState;
  logic dirRead, nextDir;
  logic useRestart, nextRestart;
  logic headRead, headStop, headRs;

  assign headRead = headWord[CMD_RD_BIT];
  assign headStop = headWord[CMD_STP_BIT];
  assign headRs   = headWord[CMD_RS_BIT];

  assign busActive = (state != S_IDLE);
  assign busHold   = (state == S_NEXT) && cmdEmpty;

  always_comb begin
    nextState   = state;
    nextDir     = dirRead;
    nextRestart = useRestart;
    ctl         = '0;
    priReq      = 1'b0;
    priOp       = OP_START;
    priWrByte   = '0;
    priAckOut   = 1'b0;
    abortEvt    = 1'b0;
    startDet    = 1'b0;
    stopDet     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (enableStatus && enableReq && !cmdEmpty) begin
          nextDir      = headRead;
          nextRestart  = 1'b0;
          ctl.clrAbort = 1'b1;
          nextState    = S_START;
        end
      end
      S_START: begin
        priReq = 1'b1;
        priOp  = useRestart ? OP_RESTART : OP_START;
        if (priDone) begin
          startDet  = 1'b1;
          nextState = S_ADDR;
        end
      end
      S_ADDR: begin
        priReq    = 1'b1;
        priOp     = OP_WRITE;
        priWrByte = {targetAddr, dirRead};
        if (priDone) begin
          if (priArbLost) begin
            abortEvt       = 1'b1;
            ctl.setArbLost = 1'b1;
            ctl.flush      = 1'b1;
            nextState      = S_IDLE;
          end else if (!priAckIn) begin
            abortEvt        = 1'b1;
            ctl.setAddrNack = 1'b1;
            ctl.flush       = 1'b1;
            nextState       = S_STOP;
          end else begin
            nextState = S_XFER;
          end
        end
      end
      S_XFER: begin
        priReq    = 1'b1;
        priOp     = dirRead ? OP_READ : OP_WRITE;
        priWrByte = dirRead ? '0 : headWord[DATA_W-1:0];
        priAckOut = dirRead && !headStop;
        if (priDone) begin
          if (!dirRead && priArbLost) begin
            abortEvt       = 1'b1;
            ctl.setArbLost = 1'b1;
            ctl.flush      = 1'b1;
            nextState      = S_IDLE;
          end else if (!dirRead && !priAckIn) begin
            abortEvt        = 1'b1;
            ctl.setDataNack = 1'b1;
            ctl.flush       = 1'b1;
            nextState       = S_STOP;
          end else begin
            ctl.cmdPop = 1'b1;
            ctl.rxPush = dirRead;
            nextState  = headStop ? S_STOP : S_NEXT;
          end
        end
      end
      S_NEXT: begin
        if (!cmdEmpty) begin
          if (headRs || (headRead != dirRead)) begin
            nextDir     = headRead;
            nextRestart = 1'b1;
            nextState   = S_START;
          end else begin
            nextState = S_XFER;
          end
        end else if (!enableReq) begin
          nextState = S_STOP;
        end
      end
      S_STOP: begin
        priReq = 1'b1;
        priOp  = OP_STOP;
        if (priDone) begin
          stopDet   = 1'b1;
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= S_IDLE;
      dirRead      <= 1'b0;
      useRestart   <= 1'b0;
      enableStatus <= 1'b0;
    end else begin
      state      <= nextState;
      dirRead    <= nextDir;
      useRestart <= nextRestart;
      if (state == S_IDLE) enableStatus <= enableReq;
    end
  end

  // R7: a completed STOP leaves the block idle
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !busActive);
  // R2: enable status only falls while idle
  a_r2_disable_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enableStatus) |-> !busActive);
  // R3: a pending primitive stays requested and unchanged
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (priReq && !priDone) |=> (priReq && $stable(priOp)));
  // R11: lost arbitration releases the bus without a STOP
  a_r11_arb_no_stop: assert property (@(posedge clk) disable iff (!rstN)
    (priReq && priDone && priArbLost && priOp == OP_WRITE) |=> !priReq);
  // R9: an abort empties the command queue
  a_r9_abort_flush: assert property (@(posedge clk) disable iff (!rstN)
    abortEvt |=> cmdEmpty);
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
  import i2cseq_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int RX_DEPTH  = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enableReq,
  output logic         enableStatus,
  output logic         busActive,
  output logic         busHold,
  input  logic [6:0]   targetAddr,
  input  logic         cmdPush,
  input  logic [10:0]  cmdWord,
  output logic         cmdFull,
  input  logic         rxPop,
  output logic [7:0]   rxData,
  output logic         rxEmpty,
  output logic         rxFull,
  output logic         priReq,
  output logic [2:0]   priOp,
  output logic [7:0]   priWrByte,
  output logic         priAckOut,
  input  logic         priDone,
  input  logic         priAckIn,
  input  logic         priArbLost,
  input  logic [7:0]   priRdByte,
  output logic [12:0]  abortSrc,
  output logic         abortEvt,
  output logic         startDet,
  output logic         stopDet
);
  dpCtl_t ctl;
  logic [CMD_W-1:0] headWord;
  logic cmdEmpty;
  busOp_e opEnum;

  assign priOp = opEnum;

  seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .enableReq(enableReq), .targetAddr(targetAddr),
    .headWord(headWord), .cmdEmpty(cmdEmpty),
    .priDone(priDone), .priAckIn(priAckIn), .priArbLost(priArbLost),
    .ctl(ctl), .priReq(priReq), .priOp(opEnum), .priWrByte(priWrByte),
    .priAckOut(priAckOut), .enableStatus(enableStatus),
    .busActive(busActive), .busHold(busHold),
    .abortEvt(abortEvt), .startDet(startDet), .stopDet(stopDet)
  );

  seq_dpath #(.CMD_DEPTH(CMD_DEPTH), .RX_DEPTH(RX_DEPTH)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .enableStatus(enableStatus),
    .cmdPush(cmdPush), .cmdWord(cmdWord), .priRdByte(priRdByte),
    .rxPop(rxPop), .headWord(headWord), .cmdEmpty(cmdEmpty),
    .cmdFull(cmdFull), .rxData(rxData), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .abortSrc(abortSrc)
  );
endmodule

// File: tb/test_i2c_cmd_sequencer.sv
module test_i2c_cmd_sequencer;
  import i2cseq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam logic [6:0] TADDR = 7'h2C;

  logic clk = 1'b0, rstN = 1'b0, enableReq = 1'b0;
  logic enableStatus, busActive, busHold, cmdFull, rxEmpty, rxFull;
  logic taskPush = 1'b0, injPush = 1'b0, cmdPush;
  logic [10:0] taskWord = '0, injWord = '0, cmdWord;
  logic rxPop = 1'b0;
  logic [7:0] rxData, priWrByte, priRdByte = '0;
  logic priReq, priAckOut, priDone = 1'b0, priAckIn = 1'b0, priArbLost = 1'b0;
  logic [2:0] priOp;
  logic [12:0] abortSrc;
  logic abortEvt, startDet, stopDet;

  assign cmdPush = taskPush | injPush;
  assign cmdWord = injPush ? injWord : taskWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_sequencer i_i2c_cmd_sequencer (
    .clk(clk), .rstN(rstN), .enableReq(enableReq), .enableStatus(enableStatus),
    .busActive(busActive), .busHold(busHold), .targetAddr(TADDR),
    .cmdPush(cmdPush), .cmdWord(cmdWord), .cmdFull(cmdFull),
    .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .priReq(priReq), .priOp(priOp), .priWrByte(priWrByte), .priAckOut(priAckOut),
    .priDone(priDone), .priAckIn(priAckIn), .priArbLost(priArbLost),
    .priRdByte(priRdByte), .abortSrc(abortSrc), .abortEvt(abortEvt),
    .startDet(startDet), .stopDet(stopDet)
  );

  int nChecks = 0, nFail = 0;
  int logOp[64], logByte[64], logAck[64], logN = 0;
  int expOp[64], expByte[64], expAck[64], expN = 0;
  int waitCnt = 0, wrIdx = 0, rdIdx = 0, nackWr = -1, arbWr = -1;
  bit injectOnAbort = 1'b0;
  int startCnt = 0, stopCnt = 0, abortCnt = 0;
  bit finished = 1'b0;

  // bus primitive model: completes each request LAT cycles after it appears
  always @(negedge clk) begin
    injPush = 1'b0;
    if (!rstN) begin
      priDone = 1'b0; waitCnt = 0;
    end else if (priDone) begin
      priDone = 1'b0; priAckIn = 1'b0; priArbLost = 1'b0;
    end else if (priReq) begin
      if (waitCnt == LAT - 1) begin
        waitCnt = 0; priDone = 1'b1; priAckIn = 1'b1; priArbLost = 1'b0;
        if (priOp == 3'(OP_WRITE)) begin
          if (wrIdx == nackWr) begin
            priAckIn = 1'b0;
            if (injectOnAbort) begin
              injPush = 1'b1;
              injWord = {1'b0, 1'b1, 1'b0, 8'hE7};
            end
          end
          if (wrIdx == arbWr) priArbLost = 1'b1;
          wrIdx++;
        end
        if (priOp == 3'(OP_READ)) begin
          priRdByte = 8'hC3 ^ 8'(rdIdx);
          rdIdx++;
        end
        if (logN < 64) begin
          logOp[logN]   = int'(priOp);
          logByte[logN] = (priOp == 3'(OP_WRITE)) ? int'(priWrByte) : 0;
          logAck[logN]  = (priOp == 3'(OP_READ)) ? int'(priAckOut) : 0;
          logN++;
        end
      end else begin
        waitCnt++;
      end
    end
  end

  // event monitor, a quarter period before the rising edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (startDet) startCnt++;
    if (stopDet)  stopCnt++;
    if (abortEvt) abortCnt++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] wr(input logic [7:0] d, input bit stp, input bit rs);
    return {rs, stp, 1'b0, d};
  endfunction
  function automatic logic [10:0] rd(input bit stp, input bit rs);
    return {rs, stp, 1'b1, 8'h00};
  endfunction

  task automatic push(input logic [10:0] w);
    while (cmdFull) @(negedge clk);
    taskPush = 1'b1; taskWord = w;
    @(negedge clk);
    taskPush = 1'b0;
  endtask

  task automatic popRx();
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic newScn();
    logN = 0; expN = 0; wrIdx = 0; rdIdx = 0; nackWr = -1; arbWr = -1;
    injectOnAbort = 1'b0; startCnt = 0; stopCnt = 0; abortCnt = 0;
  endtask

  task automatic expAdd(input busOp_e op, input int b, input int a);
    expOp[expN] = int'(op); expByte[expN] = b; expAck[expN] = a; expN++;
  endtask

  task automatic waitIdle();
    int t = 0;
    repeat (2) @(negedge clk);
    while (busActive && t < 3000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
  endtask

  task automatic compareTrace(input string req);
    check(req, "trace length", logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      check(req, $sformatf("op[%0d]", i), logOp[i], expOp[i]);
      check(req, $sformatf("byte[%0d]", i), logByte[i], expByte[i]);
      check(req, $sformatf("ack[%0d]", i), logAck[i], expAck[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFail++; nChecks++;
      $display("FAIL watchdog run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "busActive", int'(busActive), 0);
    check("R1", "enableStatus", int'(enableStatus), 0);
    check("R1", "rxEmpty", int'(rxEmpty), 1);
    check("R1", "abortSrc", int'(abortSrc), 0);
    check("R1", "priReq", int'(priReq), 0);

    // R2 pushes while disabled are dropped
    newScn();
    push(wr(8'hAA, 1, 0));
    repeat (4) @(negedge clk);
    enableReq = 1'b1;
    repeat (20) @(negedge clk);
    check("R2", "enableStatus", int'(enableStatus), 1);
    check("R2", "no traffic", logN, 0);
    check("R2", "busActive", int'(busActive), 0);

    // R3 R4 R5 R6 R7 sweep: nW writes followed by nR reads
    for (int nW = 0; nW < 3; nW++) begin
      for (int nR = 0; nR < 4; nR++) begin
        if (nW + nR == 0) continue;
        newScn();
        for (int i = 0; i < nW; i++)
          push(wr(8'(8'h20 + 3 * i), (nR == 0) && (i == nW - 1), 0));
        for (int i = 0; i < nR; i++) push(rd(i == nR - 1, 0));
        waitIdle();
        expAdd(OP_START, 0, 0);
        if (nW > 0) begin
          expAdd(OP_WRITE, {TADDR, 1'b0}, 0);
          for (int i = 0; i < nW; i++) expAdd(OP_WRITE, 8'h20 + 3 * i, 0);
          if (nR > 0) begin
            expAdd(OP_RESTART, 0, 0);
            expAdd(OP_WRITE, {TADDR, 1'b1}, 0);
          end
        end else begin
          expAdd(OP_WRITE, {TADDR, 1'b1}, 0);
        end
        for (int i = 0; i < nR; i++) expAdd(OP_READ, 0, (i != nR - 1) ? 1 : 0);
        expAdd(OP_STOP, 0, 0);
        compareTrace("R3_R4_R5_R6_R7");
        check("R3", "startDet count", startCnt, ((nW > 0) && (nR > 0)) ? 2 : 1);
        check("R7", "stopDet count", stopCnt, 1);
        check("R7", "idle", int'(busActive), 0);
        for (int i = 0; i < nR; i++) begin
          check("R5", "rx not empty", int'(rxEmpty), 0);
          check("R5", "rx byte", int'(rxData), int'(8'hC3 ^ 8'(i)));
          popRx();
        end
        check("R5", "rx drained", int'(rxEmpty), 1);
      end
    end

    // R6 explicit repeated START without direction change
    newScn();
    push(wr(8'h61, 0, 0));
    push(wr(8'h62, 1, 1));
    waitIdle();
    expAdd(OP_START, 0, 0); expAdd(OP_WRITE, {TADDR, 1'b0}, 0);
    expAdd(OP_WRITE, 8'h61, 0); expAdd(OP_RESTART, 0, 0);
    expAdd(OP_WRITE, {TADDR, 1'b0}, 0); expAdd(OP_WRITE, 8'h62, 0);
    expAdd(OP_STOP, 0, 0);
    compareTrace("R6");
    check("R6", "startDet count", startCnt, 2);

    // R8 bus held while the queue is dry
    newScn();
    push(wr(8'h11, 0, 0));
    repeat (25) @(negedge clk);
    check("R8", "busHold", int'(busHold), 1);
    check("R8", "priReq", int'(priReq), 0);
    check("R8", "busActive", int'(busActive), 1);
    push(wr(8'h22, 1, 0));
    waitIdle();
    expAdd(OP_START, 0, 0); expAdd(OP_WRITE, {TADDR, 1'b0}, 0);
    expAdd(OP_WRITE, 8'h11, 0); expAdd(OP_WRITE, 8'h22, 0); expAdd(OP_STOP, 0, 0);
    compareTrace("R8");

    // R14 disable while holding
    newScn();
    push(wr(8'h33, 0, 0));
    repeat (25) @(negedge clk);
    enableReq = 1'b0;
    waitIdle();
    expAdd(OP_START, 0, 0); expAdd(OP_WRITE, {TADDR, 1'b0}, 0);
    expAdd(OP_WRITE, 8'h33, 0); expAdd(OP_STOP, 0, 0);
    compareTrace("R14");
    check("R14", "enableStatus", int'(enableStatus), 0);
    enableReq = 1'b1;
    repeat (3) @(negedge clk);

    // R9 address NACK, with R13 push injected in the flush cycle
    newScn();
    nackWr = 0; injectOnAbort = 1'b1;
    push(wr(8'h01, 0, 0));
    push(wr(8'h02, 1, 0));
    waitIdle();
    repeat (30) @(negedge clk);
    expAdd(OP_START, 0, 0); expAdd(OP_WRITE, {TADDR, 1'b0}, 0); expAdd(OP_STOP, 0, 0);
    compareTrace("R9_R13");
    check("R9", "abortSrc", int'(abortSrc), 13'h0001);
    check("R9", "abortEvt count", abortCnt, 1);
    check("R13", "no restart after flush", startCnt, 1);
    check("R12", "abortSrc held", int'(abortSrc), 13'h0001);

    // R10 data NACK after reads: both queues flushed
    newScn();
    nackWr = 2;
    push(rd(0, 0));
    push(rd(0, 0));
    push(wr(8'h77, 1, 0));
    waitIdle();
    expAdd(OP_START, 0, 0); expAdd(OP_WRITE, {TADDR, 1'b1}, 0);
    expAdd(OP_READ, 0, 1); expAdd(OP_READ, 0, 1);
    expAdd(OP_RESTART, 0, 0); expAdd(OP_WRITE, {TADDR, 1'b0}, 0);
    expAdd(OP_WRITE, 8'h77, 0); expAdd(OP_STOP, 0, 0);
    compareTrace("R10");
    check("R10", "abortSrc (R12 cleared old bit)", int'(abortSrc), 13'h0008);
    check("R10", "rx flushed", int'(rxEmpty), 1);
    check("R10", "abortEvt count", abortCnt, 1);

    // R11 arbitration lost on first data byte
    newScn();
    arbWr = 1;
    push(wr(8'h44, 0, 0));
    push(wr(8'h45, 1, 0));
    waitIdle();
    repeat (20) @(negedge clk);
    expAdd(OP_START, 0, 0); expAdd(OP_WRITE, {TADDR, 1'b0}, 0); expAdd(OP_WRITE, 8'h44, 0);
    compareTrace("R11");
    check("R11", "abortSrc", int'(abortSrc), 13'h1000);
    check("R11", "no STOP", stopCnt, 0);
    check("R11", "idle", int'(busActive), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule